// File: doc/BRIEF.md
# Buffered-Period 10-bit PWM Timer

This block is an up-counting timer that produces one pulse-width-modulated output. The period is fixed by an active TOP register: the count climbs from zero to TOP, then returns to zero on the next counting step. The count advances only on cycles where an external prescaler raises its tick enable, so the timer can run at any integer fraction of the system clock.

Software reaches the 10-bit TOP and duty values through an 8-bit write port. A write to the high-byte select stores the upper two bits in a latch. A later write to the low byte of TOP or duty joins the latched bits with the new low byte and commits all ten bits at once. Committed values land in shadow registers. They are copied into the active registers only at the wrap from TOP to zero, so a period in progress is never cut short or stretched. A TOP value below 3 is raised to 3. Each wrap produces a one-cycle period-complete pulse.

Top module: `buffered_pwm_timer`

## Requirements
- R1: After reset the count is 0, active and shadow TOP are 0x3FF, active and shadow duty are 0, the high-byte latch is 0, the PWM output is low and the period-complete pulse is low.
- R2: The count changes only on a rising edge where tick_en is high, and then rises by exactly one unless it equals the active TOP.
- R3: On a tick where the count equals the active TOP, the next count is 0. The count never exceeds the active TOP.
- R4: period_done is high for exactly one clock cycle, in the cycle after the tick that wrapped the count to 0.
- R5: A committed TOP or duty value goes to a shadow register. The active register takes the shadow value only on the wrapping tick, and keeps its value at every other time.
- R6: A TOP value below 3 (0, 1 or 2) is stored as 3, so the shortest period is four ticks.
- R7: wr_sel encodes the target: 0 stores wr_data[1:0] in the high-byte latch, 1 commits TOP as {latch, wr_data}, 2 commits duty as {latch, wr_data}, and 3 has no effect. The latch keeps its value across commits. The write is sampled on the rising edge where wr_strobe is high, and the shadow register holds the value after the next rising edge.
- R8: pwm_out is high while the count is less than the active duty, and low otherwise. A duty of 0 keeps it low for the whole period. A duty above TOP keeps it high for the whole period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Prescaler clock enable; the count advances only when this is high |
| wr_strobe | input | 1 | Write request for the current cycle |
| wr_sel | input | 2 | Write target: 0 high-byte latch, 1 TOP low byte, 2 duty low byte, 3 unused |
| wr_data | input | 8 | Write data byte |
| count | output | 10 | Current counter value |
| pwm_out | output | 1 | PWM output |
| period_done | output | 1 | One-cycle pulse after each wrap to zero |

## Verification
The bench builds the timer with its default parameters: a 10-bit count, an 8-bit bus and a floor of 3 on TOP. With these values the full reset period of 1024 ticks fits easily in a run, so a complete period at the reset TOP is observed before any write. Short periods then exercise the floor, a mid-range TOP of 0x102 exercises the high-byte latch, and a duty of 0x3FF above TOP exercises the always-high edge case.

// File: rtl/pwm_tmr_pkg.sv
package pwm_tmr_pkg;
  typedef enum logic [1:0] {
    SEL_HIGH = 2'd0,
    SEL_TOP  = 2'd1,
    SEL_DUTY = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/pwm_bus_port.sv
module pwm_bus_port
  import pwm_tmr_pkg::*;
#(
  parameter int VAL_W = 10,
  parameter int BUS_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_strobe,
  input  logic [1:0]       wr_sel,
  input  logic [BUS_W-1:0] wr_data,
  output logic             top_wr,
  output logic             duty_wr,
  output logic [VAL_W-1:0] wr_value
);
  localparam int HI_W = VAL_W - BUS_W;

  logic             stg_vld;
  reg_sel_e         stg_sel;
  logic [BUS_W-1:0] stg_data;
  logic [HI_W-1:0]  hi_q;

  // input stage: registers the request so control reaches the timer logic one edge later
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stg_vld  <= 1'b0;
      stg_sel  <= SEL_NONE;
      stg_data <= '0;
    end else begin
      stg_vld  <= wr_strobe;
      stg_sel  <= reg_sel_e'(wr_sel);
      stg_data <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hi_q <= '0;
    end else if (stg_vld && stg_sel == SEL_HIGH) begin
      hi_q <= stg_data[HI_W-1:0];
    end
  end

  assign top_wr   = stg_vld && (stg_sel == SEL_TOP);
  assign duty_wr  = stg_vld && (stg_sel == SEL_DUTY);
  assign wr_value = {hi_q, stg_data};

  assert_commit_source_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (top_wr || duty_wr) |-> ($past(wr_strobe) && $past(wr_sel) != 2'd0 && $past(wr_sel) != 2'd3));

  assert_latch_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(stg_vld && stg_sel == SEL_HIGH) |=> $stable(hi_q));
endmodule

// File: rtl/pwm_buffered_reg.sv
module pwm_buffered_reg #(
  parameter int W         = 10,
  parameter int RESET_VAL = 0,
  parameter int CLAMP     = 0,
  parameter int MIN_VAL   = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr,
  input  logic [W-1:0] wr_value,
  input  logic         load,
  output logic [W-1:0] active
);
  localparam logic [W-1:0] RST_L = W'(RESET_VAL);
  localparam logic [W-1:0] MIN_L = W'(MIN_VAL);

  logic [W-1:0] shadow_q;
  logic [W-1:0] active_q;
  logic [W-1:0] wr_fixed;

  generate
    if (CLAMP != 0) begin : g_floor
      assign wr_fixed = (wr_value < MIN_L) ? MIN_L : wr_value;
    end else begin : g_pass
      assign wr_fixed = wr_value;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shadow_q <= RST_L;
    end else if (wr) begin
      shadow_q <= wr_fixed;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q <= RST_L;
    end else if (load) begin
      active_q <= shadow_q;
    end
  end

  assign active = active_q;

  assert_active_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(active_q));

  assert_shadow_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !wr |=> $stable(shadow_q));

  generate
    if (CLAMP != 0) begin : g_floor_chk
      assert_top_floor_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (shadow_q >= MIN_L) && (active_q >= MIN_L));
    end
  endgenerate
endmodule

// File: rtl/pwm_counter.sv
module pwm_counter #(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ce,
  input  logic [W-1:0] top,
  output logic [W-1:0] cnt,
  output logic         wrap,
  output logic         done
);
  logic [W-1:0] cnt_q;
  logic         done_q;

  assign wrap = ce && (cnt_q == top);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= wrap;
      if (wrap) begin
        cnt_q <= '0;
      end else if (ce) begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign cnt  = cnt_q;
  assign done = done_q;

  assert_count_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= top);

  assert_stall_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !ce |=> $stable(cnt_q));

  assert_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ce && cnt_q != top) |=> (cnt_q == $past(cnt_q) + 1'b1));

  assert_wrap_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ce && cnt_q == top) |=> (cnt_q == '0));
endmodule

// File: rtl/buffered_pwm_timer.sv
module buffered_pwm_timer
  import pwm_tmr_pkg::*;
#(
  parameter int CNT_W   = 10,
  parameter int BUS_W   = 8,
  parameter int MIN_TOP = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic             wr_strobe,
  input  logic [1:0]       wr_sel,
  input  logic [BUS_W-1:0] wr_data,
  output logic [CNT_W-1:0] count,
  output logic             pwm_out,
  output logic             period_done
);
  localparam int TOP_RST = (1 << CNT_W) - 1;

  logic             top_wr;
  logic             duty_wr;
  logic [CNT_W-1:0] wr_value;
  logic [CNT_W-1:0] top_act;
  logic [CNT_W-1:0] duty_act;
  logic [CNT_W-1:0] cnt;
  logic             wrap;
  logic             done;

  pwm_bus_port #(.VAL_W(CNT_W), .BUS_W(BUS_W)) u_bus (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_strobe(wr_strobe),
    .wr_sel   (wr_sel),
    .wr_data  (wr_data),
    .top_wr   (top_wr),
    .duty_wr  (duty_wr),
    .wr_value (wr_value)
  );

  pwm_buffered_reg #(.W(CNT_W), .RESET_VAL(TOP_RST), .CLAMP(1), .MIN_VAL(MIN_TOP)) u_top (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr      (top_wr),
    .wr_value(wr_value),
    .load    (wrap),
    .active  (top_act)
  );

  pwm_buffered_reg #(.W(CNT_W), .RESET_VAL(0), .CLAMP(0), .MIN_VAL(0)) u_duty (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr      (duty_wr),
    .wr_value(wr_value),
    .load    (wrap),
    .active  (duty_act)
  );

  pwm_counter #(.W(CNT_W)) u_cnt (
    .clk  (clk),
    .rst_n(rst_n),
    .ce   (tick_en),
    .top  (top_act),
    .cnt  (cnt),
    .wrap (wrap),
    .done (done)
  );

  assign count       = cnt;
  assign pwm_out     = (cnt < duty_act);
  assign period_done = done;

  assert_done_at_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    period_done |-> (count == '0));

  assert_done_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    period_done |=> !period_done);

  assert_pwm_zero_duty_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (duty_act == '0) |-> !pwm_out);
endmodule

// File: tb/test_buffered_pwm_timer.sv
module test_buffered_pwm_timer;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_en = 1'b0;
  logic       wr_strobe = 1'b0;
  logic [1:0] wr_sel = 2'd3;
  logic [7:0] wr_data = 8'd0;
  logic [9:0] count;
  logic       pwm_out;
  logic       period_done;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  buffered_pwm_timer i_buffered_pwm_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick_en    (tick_en),
    .wr_strobe  (wr_strobe),
    .wr_sel     (wr_sel),
    .wr_data    (wr_data),
    .count      (count),
    .pwm_out    (pwm_out),
    .period_done(period_done)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [1:0] sel, input logic [7:0] data);
    @(negedge clk);
    wr_strobe = 1'b1; wr_sel = sel; wr_data = data;
    @(negedge clk);
    wr_strobe = 1'b0; wr_sel = 2'd3;
    @(negedge clk);
  endtask

  task automatic run_ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      tick_en = 1'b1;
    end
    @(negedge clk);
    tick_en = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic t_reset;
    check("R1 count", int'(count), 0);
    check("R1 pwm", int'(pwm_out), 0);
    check("R1 done", int'(period_done), 0);
  endtask

  task automatic t_default_period;
    run_ticks(1023);
    check("R1 top reset 0x3FF count", int'(count), 1023);
    check("R4 no early done", int'(period_done), 0);
    run_ticks(1);
    check("R3 wrap", int'(count), 0);
    check("R4 done pulse", int'(period_done), 1);
    idle(1);
    check("R4 done one cycle", int'(period_done), 0);
  endtask

  task automatic t_hold;
    run_ticks(7);
    check("R2 advance", int'(count), 7);
    idle(5);
    check("R2 hold without tick", int'(count), 7);
    run_ticks(1016);
    check("R2 reach top", int'(count), 1023);
    run_ticks(1);
    check("R3 wrap after hold", int'(count), 0);
  endtask

  task automatic t_buffered;
    do_write(2'd0, 8'd0);
    do_write(2'd1, 8'd5);
    do_write(2'd2, 8'd2);
    run_ticks(10);
    check("R5 top not applied mid-period", int'(count), 10);
    check("R5 duty not applied mid-period", int'(pwm_out), 0);
    run_ticks(1013);
    check("R5 old top kept", int'(count), 1023);
    run_ticks(1);
    check("R5 wrap", int'(count), 0);
    check("R8 pwm high at 0", int'(pwm_out), 1);
    run_ticks(1);
    check("R8 pwm high at 1", int'(pwm_out), 1);
    run_ticks(1);
    check("R8 pwm low at duty", int'(pwm_out), 0);
    run_ticks(3);
    check("R5 new top reached", int'(count), 5);
    run_ticks(1);
    check("R3 wrap at new top", int'(count), 0);
    check("R4 done at new top", int'(period_done), 1);
  endtask

  task automatic t_clamp;
    do_write(2'd1, 8'd1);
    run_ticks(6);
    check("R6 wrap before clamp", int'(count), 0);
    run_ticks(3);
    check("R6 top 1 clamped to 3", int'(count), 3);
    run_ticks(1);
    check("R6 wrap at 3", int'(count), 0);
    do_write(2'd1, 8'd0);
    run_ticks(4);
    check("R6 wrap before zero write", int'(count), 0);
    run_ticks(3);
    check("R6 top 0 clamped to 3", int'(count), 3);
    run_ticks(1);
    check("R6 wrap at 3 again", int'(count), 0);
  endtask

  task automatic t_hilatch;
    do_write(2'd0, 8'd1);
    do_write(2'd1, 8'd2);
    do_write(2'd0, 8'd3);
    do_write(2'd2, 8'hFF);
    do_write(2'd3, 8'd7);
    run_ticks(4);
    check("R7 wrap", int'(count), 0);
    check("R8 duty above top high at 0", int'(pwm_out), 1);
    run_ticks(258);
    check("R7 top 0x102", int'(count), 258);
    check("R8 duty above top high at top", int'(pwm_out), 1);
    run_ticks(1);
    check("R7 wrap at 0x102, sel 3 ignored", int'(count), 0);
  endtask

  task automatic t_duty_zero;
    do_write(2'd0, 8'd0);
    do_write(2'd2, 8'd0);
    check("R5 duty old until wrap", int'(pwm_out), 1);
    run_ticks(259);
    check("R3 wrap", int'(count), 0);
    check("R8 duty 0 low at 0", int'(pwm_out), 0);
    run_ticks(100);
    check("R8 duty 0 low mid", int'(pwm_out), 0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);
    t_reset();
    t_default_period();
    t_hold();
    t_buffered();
    t_clamp();
    t_hilatch();
    t_duty_zero();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule